// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block totals the value of coins dropped into a single slot and tells the dispensing mechanism when a package may be released. A coin sensor upstream delivers a one-cycle pulse on one of two pins: one for a 5-unit coin and one for a 10-unit coin. The price is 15 units. The controller keeps track of the credit so far in one of four steps (0, 5, 10, and 15 or more) and raises its release output once the price has been covered. It gives no change. Two 10-unit coins still produce a single release.

A build-time parameter chooses how the release output is formed. In registered-state mode the output is decoded from the stored credit alone, so it rises in the cycle after the paying coin. In transition mode the output also goes high in the same cycle as the coin that completes payment. Once full credit is reached, the controller stays there until reset. The coin pins are plain control strobes and have no handshake.

Top module: `vend_ctrl`

## Requirements
- R1: An active-low asynchronous reset `rst_n` clears the credit to zero. While reset is held and no paying coin is present, `release_o` is low in both modes.
- R2: A pulse on `nickel_i` alone raises the credit by one step (0→5→10→15) at the next rising clock edge.
- R3: A pulse on `dime_i` alone raises the credit by two steps and saturates at full credit: 0→10, 5→15, 10→15.
- R4: A cycle with neither coin pin high leaves the credit unchanged.
- R5: A cycle with both coin pins high is treated as no coin and leaves the credit unchanged.
- R6: Full credit is held until reset. Further coins of either kind change nothing, and `release_o` stays high.
- R7: With `MEALY_OUT = 0`, `release_o` is high exactly while the stored credit is full.
- R8: With `MEALY_OUT = 1`, `release_o` is high while the stored credit is full. It is also high in any cycle where a single valid coin would bring the credit to full: a nickel at 10, or a dime at 5 or 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nickel_i | input | 1 | One-cycle strobe for a 5-unit coin |
| dime_i | input | 1 | One-cycle strobe for a 10-unit coin |
| release_o | output | 1 | Package release request |

## Verification
The bench builds two copies side by side from the same stimulus: one with `MEALY_OUT = 0` and one with `MEALY_OUT = 1`. This covers both output forms and the difference of one cycle between them. After each reset the bench applies every sequence of four cycles drawn from none, nickel, dime and both-at-once, which is 256 sequences. This reaches every credit level under every input, including the saturating dime at 10 and coins arriving after full credit. Expected outputs come from a small credit counter in the bench that saturates at three steps.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CREDIT_W = 2;

  typedef enum logic [CREDIT_W-1:0] {
    CR_ZERO = 2'b00,
    CR_FIVE = 2'b01,
    CR_TEN  = 2'b10,
    CR_FULL = 2'b11
  } credit_e;

  typedef struct packed {
    logic nickel;
    logic dime;
  } coin_t;
endpackage

// File: rtl/vend_coin_qual.sv
module vend_coin_qual
  import vend_pkg::*;
(
  input  logic  nickel_raw,
  input  logic  dime_raw,
  output coin_t coin
);
  // A cycle with both strobes high is rejected as an ambiguous coin.
  always_comb begin
    coin.nickel = nickel_raw & ~dime_raw;
    coin.dime   = dime_raw & ~nickel_raw;
  end
endmodule

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  credit_e cur,
  input  coin_t   coin,
  output credit_e nxt
);
  logic hi, lo, hi_n, lo_n;

  always_comb begin
    hi   = cur[1];
    lo   = cur[0];
    hi_n = hi | coin.dime | (coin.nickel & lo);
    lo_n = (coin.nickel & ~lo) | (~coin.nickel & lo) | (coin.dime & hi);
    if (cur == CR_FULL) nxt = CR_FULL;
    else                nxt = credit_e'({hi_n, lo_n});
  end
endmodule

// File: rtl/vend_out.sv
module vend_out
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  credit_e cur,
  input  coin_t   coin,
  output logic    release_o
);
  generate
    if (MEALY_OUT) begin : g_arc
      always_comb
        release_o = (cur == CR_FULL) |
                    ((cur == CR_TEN) & (coin.nickel | coin.dime)) |
                    ((cur == CR_FIVE) & coin.dime);
    end else begin : g_state
      always_comb release_o = cur[1] & cur[0];
    end
  endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nickel_i,
  input  logic dime_i,
  output logic release_o
);
  coin_t   coin;
  credit_e credit_q, credit_d;

  vend_coin_qual u_qual (
    .nickel_raw (nickel_i),
    .dime_raw   (dime_i),
    .coin       (coin)
  );

  vend_next u_next (
    .cur  (credit_q),
    .coin (coin),
    .nxt  (credit_d)
  );

  vend_out #(.MEALY_OUT(MEALY_OUT)) u_out (
    .cur       (credit_q),
    .coin      (coin),
    .release_o (release_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= CR_ZERO;
    else        credit_q <= credit_d;
  end

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!nickel_i && !dime_i) |=> $stable(credit_q));
  a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nickel_i && dime_i) |=> $stable(credit_q));
  a_r6_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_q == CR_FULL) |=> (credit_q == CR_FULL) && release_o);
  a_r2_nickel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (nickel_i && !dime_i && credit_q == CR_TEN) |=> (credit_q == CR_FULL));
  a_r3_dime_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dime_i && !nickel_i && credit_q == CR_ZERO) |=> (credit_q == CR_TEN));
  a_r8_arc_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o && credit_q != CR_FULL) |=> (credit_q == CR_FULL));
  a_r7_rise_after_coin: assert property (@(posedge clk) disable iff (!rst_n)
    (!MEALY_OUT && $rose(release_o)) |-> $past(nickel_i ^ dime_i));
endmodule

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nickel_i = 1'b0;
  logic dime_i = 1'b0;
  logic rel_moore, rel_mealy;
  int   n_vec = 0;
  int   n_bad = 0;
  int   units = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl #(.MEALY_OUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .nickel_i(nickel_i), .dime_i(dime_i),
    .release_o(rel_moore));
  vend_ctrl #(.MEALY_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .nickel_i(nickel_i), .dime_i(dime_i),
    .release_o(rel_mealy));

  task automatic check(input logic act, input logic exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // sym: 0 none, 1 nickel, 2 dime, 3 both
  task automatic apply(input int sym);
    int  step;
    int  after;
    logic exp_moore, exp_mealy;
    @(negedge clk);
    nickel_i = (sym == 1) || (sym == 3);
    dime_i   = (sym == 2) || (sym == 3);
    #1;
    step  = (sym == 1) ? 1 : (sym == 2) ? 2 : 0;   // R2 R3 R4 R5
    after = (units == 3) ? 3 : ((units + step > 3) ? 3 : units + step); // R6
    exp_moore = (units == 3);
    exp_mealy = (units == 3) || (after == 3);
    check(rel_moore, exp_moore, "R7");
    check(rel_mealy, exp_mealy, (units == 3) ? "R6" : "R8");
    units = after;
  endtask

  initial begin
    for (int seq = 0; seq < 256; seq++) begin
      @(negedge clk);
      rst_n = 1'b0; nickel_i = 1'b0; dime_i = 1'b0;
      #1;
      check(rel_moore, 1'b0, "R1");
      check(rel_mealy, 1'b0, "R1");
      units = 0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) apply((seq >> (2*k)) & 3);
      apply(0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired at t=%0t actual=hung expected=done", $time);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule